// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes the low four bits of a branch opcode and the processor status flags, and it produces one bit that is high when the branch condition holds. Opcode bits 3 down to 1 pick one of eight flag tests. Bit 0 turns a "branch if true" test into its "branch if false" twin.

The eight tests are not built as eight separate decoders. Seven shared product terms each match a partly-don't-care opcode pattern and feed one wide NOR. The compound tests (carry-or-zero, and zero-or-sign-mismatch) therefore reuse the single-flag terms. The NOR output is then corrected in polarity by bit 0.

A parameter selects a one-cycle registered output, which is the default, or a purely combinational path. The auxiliary-carry flag comes in as a pin so the block can take the whole flag word, but it plays no part in any test. The block has no flow control: a new code and flag set may be presented every cycle. In registered mode each input set yields exactly one result, one cycle later.

Top module: `branch_cond_eval`

## Requirements
- R1: Tests are selected by cc_code[3:1]. Code 000 tests that the overflow flag is 1.
- R2: Code 001 tests that the carry flag is 1.
- R3: Code 010 tests that the zero flag is 1.
- R4: Code 011 tests that the carry flag or the zero flag is 1.
- R5: Code 100 tests that the sign flag is 1.
- R6: Code 101 tests that the parity flag is 1.
- R7: Code 110 tests that the sign flag differs from the overflow flag.
- R8: Code 111 tests that the zero flag is 1 or that the sign flag differs from the overflow flag.
- R9: cc_code[0]=0 makes cond_true equal to the selected test, and cc_code[0]=1 makes it the inverse of that test.
- R10: flag_af has no effect on cond_true for any code or flag combination.
- R11: With OUT_STAGES=1 (the default), cond_true shows the result for the inputs sampled at the previous rising clk edge. It does not change before that edge.
- R12: While rst_n is low, cond_true is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_code | input | 4 | Low four bits of the branch opcode |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| flag_af | input | 1 | Auxiliary-carry flag, accepted and ignored |
| cond_true | output | 1 | High when the selected condition holds |

## Verification
The assertions run on every cycle. They compare cond_true against a reference built from the previous cycle's code and flags. They also check the overflow, zero-based and inversion cases, and that the output stays low during reset.

Some behaviours can only be shown by the bench's scenarios:
- The full sweep of all 16 codes against every combination of the six flags.
- The pairing of each sweep point with its auxiliary-carry twin, which shows that flag never matters.
- The observation that the output does not change before the clock edge.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SEL_W     = CODE_W - 1;
  localparam int unsigned NUM_TERMS = 7;

  typedef struct packed {
    logic ovf;
    logic cry;
    logic zer;
    logic sgn;
    logic par;
  } bce_flags_t;
endpackage

// File: rtl/bce_term_array.sv
module bce_term_array
  import bce_pkg::*;
(
  input  logic [SEL_W-1:0]     sel,
  input  bce_flags_t           flags,
  output logic [NUM_TERMS-1:0] terms
);
  logic s_mis;
  assign s_mis = flags.sgn ^ flags.ovf;

  always_comb begin
    // each term: opcode pattern (with don't-cares) AND one flag test
    terms[0] = (sel == 3'b000) & flags.ovf;           // 000
    terms[1] = ~sel[2] & sel[0] & flags.cry;          // 0x1 : carry, carry|zero
    terms[2] = ~sel[2] & sel[1] & flags.zer;          // 01x : zero, carry|zero
    terms[3] = (sel == 3'b100) & flags.sgn;           // 100
    terms[4] = (sel == 3'b101) & flags.par;           // 101
    terms[5] = sel[2] & sel[1] & s_mis;               // 11x : less, less|equal
    terms[6] = (sel == 3'b111) & flags.zer;           // 111
  end
endmodule

// File: rtl/bce_combine.sv
module bce_combine
  import bce_pkg::*;
(
  input  logic [NUM_TERMS-1:0] terms,
  input  logic                 invert,
  output logic                 result
);
  logic none_hit;
  assign none_hit = ~(|terms);
  // none_hit is low when the test holds; fix polarity with invert
  assign result = none_hit ~^ invert;
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int unsigned OUT_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cc_code,
  input  logic              flag_of,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_pf,
  input  logic              flag_af,
  output logic              cond_true
);
  bce_flags_t           flags;
  logic [NUM_TERMS-1:0] terms;
  logic                 cond_c;

  assign flags = '{ovf: flag_of, cry: flag_cf, zer: flag_zf,
                   sgn: flag_sf, par: flag_pf};

  bce_term_array u_terms (
    .sel   (cc_code[CODE_W-1:1]),
    .flags (flags),
    .terms (terms)
  );

  bce_combine u_comb (
    .terms  (terms),
    .invert (cc_code[0]),
    .result (cond_c)
  );

  generate
    if (OUT_STAGES == 0) begin : g_comb
      assign cond_true = cond_c & rst_n;
    end else begin : g_reg
      logic cond_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond_c;
      end
      assign cond_true = cond_q;
    end
  endgenerate
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int unsigned OUT_STAGES = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cc_code,
  input logic       flag_of,
  input logic       flag_cf,
  input logic       flag_zf,
  input logic       flag_sf,
  input logic       flag_pf,
  input logic       flag_af,
  input logic       cond_true
);
  logic ref_base;
  always_comb begin
    case (cc_code[3:1])
      3'd0: ref_base = flag_of;
      3'd1: ref_base = flag_cf;
      3'd2: ref_base = flag_zf;
      3'd3: ref_base = flag_cf | flag_zf;
      3'd4: ref_base = flag_sf;
      3'd5: ref_base = flag_pf;
      3'd6: ref_base = (flag_sf != flag_of);
      default: ref_base = flag_zf | (flag_sf != flag_of);
    endcase
  end

  logic ref_full;
  assign ref_full = ref_base ^ cc_code[0] ^ (flag_af & 1'b0);

  generate
    if (OUT_STAGES != 0) begin : g_chk
      // R12
      always @(negedge clk) if (!rst_n) a_r12_reset_low: assert (cond_true == 1'b0);

      a_r11_ref_match: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cond_true == $past(ref_full));

      a_r1_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cc_code) == 4'b0000) |-> cond_true == $past(flag_of));

      a_r4_carry_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cc_code) == 4'b0110 && $past(flag_zf)) |-> cond_true);

      a_r8_zero_or_less: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cc_code[3:1]) == 3'b111 && $past(flag_zf))
          |-> cond_true == !$past(cc_code[0]));

      a_r9_inverted_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cc_code[0])) |-> cond_true == !$past(ref_base));
    end
  endgenerate
endmodule

bind branch_cond_eval bce_checker #(.OUT_STAGES(OUT_STAGES)) u_bce_chk (
  .clk(clk), .rst_n(rst_n), .cc_code(cc_code),
  .flag_of(flag_of), .flag_cf(flag_cf), .flag_zf(flag_zf),
  .flag_sf(flag_sf), .flag_pf(flag_pf), .flag_af(flag_af),
  .cond_true(cond_true)
);

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cc_code = '0;
  logic       f_of = 0, f_cf = 0, f_zf = 0, f_sf = 0, f_pf = 0, f_af = 0;
  logic       cond_true;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  branch_cond_eval dut (
    .clk(clk), .rst_n(rst_n), .cc_code(cc_code),
    .flag_of(f_of), .flag_cf(f_cf), .flag_zf(f_zf),
    .flag_sf(f_sf), .flag_pf(f_pf), .flag_af(f_af),
    .cond_true(cond_true)
  );

  // expected value built arithmetically from flag bits
  function automatic logic expect_of(input logic [3:0] c, input logic [5:0] f);
    logic o, cy, z, s, p, t;
    {o, cy, z, s, p} = f[4:0];
    case (c >> 1)
      0: t = o;
      1: t = cy;
      2: t = z;
      3: t = (cy + z) != 0;
      4: t = s;
      5: t = p;
      6: t = (s + o) == 1;
      default: t = z || ((s + o) == 1);
    endcase
    return c[0] ? !t : t;
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c >> 1)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b code=%h flags=%b%b%b%b%b%b",
               req, act, exp, cc_code, f_af, f_of, f_cf, f_zf, f_sf, f_pf);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [5:0] f);
    @(negedge clk);
    cc_code = c;
    {f_af, f_of, f_cf, f_zf, f_sf, f_pf} = f;
  endtask

  initial begin
    logic [5:0] fv;
    logic       prev;
    apply(4'hF, 6'h3F);
    check("R12", cond_true, 1'b0);          // reset holds output low
    repeat (2) @(negedge clk);
    check("R12", cond_true, 1'b0);
    rst_n = 1'b1;

    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 64; f++) begin
        apply(c[3:0], f[5:0]);
        @(negedge clk);
        fv = f[5:0];
        check(req_of(c[3:0]), cond_true, expect_of(c[3:0], fv));
        // R9: inversion by bit 0 against the paired code
        if (c[0]) check("R9", cond_true, !expect_of({c[3:1], 1'b0}, fv));
      end
    end

    // R10: toggling only the auxiliary-carry flag never changes the output
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        apply(c[3:0], {1'b0, f[4:0]});
        @(negedge clk);
        prev = cond_true;
        apply(c[3:0], {1'b1, f[4:0]});
        @(negedge clk);
        check("R10", cond_true, prev);
      end
    end

    // R11: output waits for the clock edge after an input change
    apply(4'b0000, 6'b000000);             // overflow test, OF=0 -> 0
    @(negedge clk);
    check("R11", cond_true, 1'b0);
    apply(4'b0000, 6'b010000);             // OF=1 -> 1 after the edge
    #1 check("R11", cond_true, 1'b0);
    @(negedge clk);
    check("R11", cond_true, 1'b1);

    // R12: asynchronous reset clears output mid-run
    #1 rst_n = 1'b0;
    #1 check("R12", cond_true, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule